// File: doc/BRIEF.md
# Barrel Thread Interleave Sequencer

This block drives the thread rotation of a barrel processor. Eight hardware threads share one pipeline whose depth also equals eight, so a new thread enters stage 0 on every clock. Any given thread occupies exactly one stage at a time. The rotation is fixed, which removes hazards, stalls and any arbitration between threads. Each thread receives one eighth of the aggregate instruction rate.

The sequencer holds one 16-bit program counter per thread. Every clock it presents the issuing thread's counter and its thread ID, which software can read to offset its private data. It also publishes the thread tag held by every pipeline stage. At writeback it turns a single commit request into a one-hot per-thread strobe. Because only the thread in the last stage can own that strobe, register file and memory writes never collide. A taken branch, tagged with the thread that resolved it, replaces that thread's counter. The datapath, decode and stacks sit outside this block.

Top module: `barrel_sequencer`

## Requirements
- R1: While reset is held, issueTid is 0 and issuePc is RESET_VEC (default 0x0000). Stage k of stageTid holds (8-k) mod 8, wbTid is 1, and wbCommit is zero while wbReq is low.
- R2: After reset, issueTid advances by one each clock through 0,1,...,7 and then wraps to 0. The first issue after reset is thread 0.
- R3: The first issue of thread t after reset presents issuePc = RESET_VEC + t*PC_STRIDE. With the defaults this is t*0x0100.
- R4: Each issue of a thread increments that thread's counter by one when no branch targets it. The incremented value appears at the thread's next issue slot, eight clocks later.
- R5: A clock with brTaken high loads brTarget into the counter of thread brTid only. The other threads' counters are unchanged, and thread brTid presents brTarget at its next issue.
- R6: When brTid equals the thread issuing in that same clock, the branch target wins over the increment. Eight clocks later the thread issues at exactly brTarget.
- R7: stageTid packs one 3-bit tag per stage, with stage k in bits [3k+2:3k]. Stage k always equals (issueTid - k) mod 8, and stage 0 equals issueTid.
- R8: wbTid equals the stage 7 tag, which is (issueTid+1) mod 8. wbCommit has only bit wbTid set when wbReq is high, and is all zero when wbReq is low.
- R9: Program counters are 16 bits wide. A thread at 0xFFFF issues next at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brTaken | input | 1 | A branch was resolved this clock |
| brTid | input | 3 | Thread that the branch belongs to |
| brTarget | input | 16 | New program counter for that thread |
| wbReq | input | 1 | The instruction in the final stage wants to commit |
| issueTid | output | 3 | Thread issuing into stage 0; the readable thread ID |
| issuePc | output | 16 | Program counter of the issuing thread |
| stageTid | output | 24 | Thread tag of each of the 8 stages, 3 bits per stage |
| wbTid | output | 3 | Thread tag in the final (writeback) stage |
| wbCommit | output | 8 | One-hot per-thread commit strobe |

## Verification
The collision that matters is a branch for the thread that is issuing in the same clock. In that clock the sequential increment and the branch load both target one counter. The bench provokes this directly by driving brTid equal to the current issue thread. Random branches also make it recur often. The bench then judges the result eight clocks later, when that thread issues again: its counter must be exactly brTarget, never brTarget+1 and never the incremented old value. A wrap from 0xFFFF is checked the same way across two successive slots.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  parameter int THREADS = 8;
  parameter int ADDR_W  = 16;
  localparam int TID_W  = $clog2(THREADS);

  typedef logic [TID_W-1:0]  tid_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // strobes from control to datapath
  typedef struct packed {
    tid_t               issueTid;
    tid_t               nextTid;
    logic [THREADS-1:0] bumpSel;
    logic [THREADS-1:0] branchSel;
    logic               commitReq;
  } seq_ctrl_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      brTaken,
  input  tid_t      brTid,
  input  logic      wbReq,
  output seq_ctrl_t ctrl
);
  tid_t issueCnt;
  tid_t nextCnt;

  always_comb begin
    if (issueCnt == tid_t'(THREADS - 1)) nextCnt = '0;
    else                                 nextCnt = issueCnt + tid_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issueCnt <= '0;
    else        issueCnt <= nextCnt;
  end

  always_comb begin
    ctrl           = '0;
    ctrl.issueTid  = issueCnt;
    ctrl.nextTid   = nextCnt;
    ctrl.bumpSel[issueCnt] = 1'b1;
    if (brTaken) ctrl.branchSel[brTid] = 1'b1;
    ctrl.commitReq = wbReq;
  end

  // rotation step of one thread per clock (modulo a power-of-two count)
  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tid_t'(ctrl.issueTid - $past(ctrl.issueTid)) == tid_t'(1)); // R2
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter addr_t RESET_VEC = '0,
  parameter addr_t PC_STRIDE = addr_t'(256)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  seq_ctrl_t                ctrl,
  input  addr_t                    brTarget,
  output addr_t                    issuePc,
  output logic [THREADS*TID_W-1:0] stageTid,
  output tid_t                     wbTid,
  output logic [THREADS-1:0]       wbCommit
);
  addr_t pcReg  [THREADS];
  tid_t  tagReg [1:THREADS-1];

  // per-thread program counters: branch load has priority over increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++)
        pcReg[t] <= RESET_VEC + PC_STRIDE * addr_t'(t);
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        if (ctrl.branchSel[t])    pcReg[t] <= brTarget;
        else if (ctrl.bumpSel[t]) pcReg[t] <= pcReg[t] + addr_t'(1);
      end
    end
  end

  assign issuePc = pcReg[ctrl.issueTid];

  // thread tags travelling down stages 1..THREADS-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < THREADS; k++)
        tagReg[k] <= tid_t'((THREADS - k) % THREADS);
    end else begin
      tagReg[1] <= ctrl.issueTid;
      for (int k = 2; k < THREADS; k++) tagReg[k] <= tagReg[k-1];
    end
  end

  always_comb begin
    stageTid[0 +: TID_W] = ctrl.issueTid;
    for (int k = 1; k < THREADS; k++) stageTid[k*TID_W +: TID_W] = tagReg[k];
  end

  assign wbTid = tagReg[THREADS-1];

  always_comb begin
    wbCommit = '0;
    if (ctrl.commitReq) wbCommit[wbTid] = 1'b1;
  end

  // the tag leaving the pipe must be the thread the control issues next
  AST_WB_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wbTid == ctrl.nextTid); // R8
  AST_COMMIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.commitReq |-> (wbCommit[ctrl.nextTid] && $onehot0(wbCommit))); // R8
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.commitReq |-> wbCommit == '0); // R8

  for (genvar t = 0; t < THREADS; t++) begin : g_pcChk
    AST_BRANCH_LAND: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.branchSel[t] |=> pcReg[t] == $past(brTarget)); // R5
    AST_SEQ_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.bumpSel[t] && !ctrl.branchSel[t]) |=> pcReg[t] == $past(pcReg[t]) + addr_t'(1)); // R4
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.bumpSel[t] && !ctrl.branchSel[t]) |=> $stable(pcReg[t])); // R5
  end
endmodule

// File: rtl/barrel_sequencer.sv
module barrel_sequencer
  import bseq_pkg::*;
#(
  parameter addr_t RESET_VEC = '0,
  parameter addr_t PC_STRIDE = addr_t'(256)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     brTaken,
  input  logic [TID_W-1:0]         brTid,
  input  logic [ADDR_W-1:0]        brTarget,
  input  logic                     wbReq,
  output logic [TID_W-1:0]         issueTid,
  output logic [ADDR_W-1:0]        issuePc,
  output logic [THREADS*TID_W-1:0] stageTid,
  output logic [TID_W-1:0]         wbTid,
  output logic [THREADS-1:0]       wbCommit
);
  seq_ctrl_t ctrl;

  bseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .brTaken (brTaken),
    .brTid   (brTid),
    .wbReq   (wbReq),
    .ctrl    (ctrl)
  );

  bseq_datapath #(
    .RESET_VEC (RESET_VEC),
    .PC_STRIDE (PC_STRIDE)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .brTarget (brTarget),
    .issuePc  (issuePc),
    .stageTid (stageTid),
    .wbTid    (wbTid),
    .wbCommit (wbCommit)
  );

  assign issueTid = ctrl.issueTid;
endmodule

// File: tb/sim_barrel_sequencer.sv
module sim_barrel_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        brTaken;
  logic [2:0]  brTid;
  logic [15:0] brTarget;
  logic        wbReq;
  logic [2:0]  issueTid;
  logic [15:0] issuePc;
  logic [23:0] stageTid;
  logic [2:0]  wbTid;
  logic [7:0]  wbCommit;

  int errors = 0;
  int checks = 0;

  logic [15:0] mPc [8];
  int          mCnt;

  barrel_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .brTaken(brTaken), .brTid(brTid),
    .brTarget(brTarget), .wbReq(wbReq), .issueTid(issueTid),
    .issuePc(issuePc), .stageTid(stageTid), .wbTid(wbTid), .wbCommit(wbCommit)
  );

  always #2 clk = ~clk;

  function automatic logic [23:0] expStages(int c);
    logic [23:0] r;
    for (int k = 0; k < 8; k++) r[k*3 +: 3] = 3'((c - k + 8) % 8);
    return r;
  endfunction

  function automatic logic [7:0] expCommit(int c, logic req);
    logic [7:0] r = '0;
    if (req) r[(c + 1) % 8] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // entered just after a falling edge; leaves just after the next falling edge
  task automatic cyc(logic br, logic [2:0] tid, logic [15:0] tgt, logic wb, string pcReq);
    chk("R2", 32'(issueTid), 32'(mCnt));
    chk(pcReq, 32'(issuePc), 32'(mPc[mCnt]));
    chk("R7", 32'(stageTid), 32'(expStages(mCnt)));
    chk("R8", 32'(wbTid), 32'((mCnt + 1) % 8));
    brTaken = br; brTid = tid; brTarget = tgt; wbReq = wb;
    #1;
    chk("R8", 32'(wbCommit), 32'(expCommit(mCnt, wb)));
    @(posedge clk);
    mPc[mCnt] = mPc[mCnt] + 16'd1;
    if (br) mPc[tid] = tgt;
    mCnt = (mCnt + 1) % 8;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20130625);
    rst_n = 1'b0; brTaken = 1'b0; brTid = '0; brTarget = '0; wbReq = 1'b0;
    for (int t = 0; t < 8; t++) mPc[t] = 16'(t * 256);
    mCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(issueTid), 0);
    chk("R1", 32'(issuePc), 0);
    chk("R1", 32'(stageTid), 32'(expStages(0)));
    chk("R1", 32'(wbTid), 1);
    chk("R1", 32'(wbCommit), 0);
    rst_n = 1'b1;

    // R3 first pass shows the per-thread reset vectors; R4 second pass shows +1
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 16'd0, i[0], "R3");
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 16'd0, 1'b1, "R4");

    // R6 branch for the thread issuing in that very clock
    cyc(1'b1, 3'(mCnt), 16'h1234, 1'b0, "R4");
    for (int i = 0; i < 7; i++) cyc(1'b0, 3'd0, 16'd0, 1'b0, "R4");
    chk("R6", 32'(issuePc), 32'h1234);
    cyc(1'b0, 3'd0, 16'd0, 1'b0, "R6");

    // R5 branch for another thread; all threads checked across a full turn
    cyc(1'b1, 3'((mCnt + 3) % 8), 16'hBEEF, 1'b1, "R5");
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 16'd0, 1'b0, "R5");

    // R9 wrap from 0xFFFF to 0x0000
    cyc(1'b1, 3'(mCnt), 16'hFFFF, 1'b0, "R5");
    for (int i = 0; i < 7; i++) cyc(1'b0, 3'd0, 16'd0, 1'b0, "R5");
    chk("R9", 32'(issuePc), 32'hFFFF);
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 16'd0, 1'b0, "R9");
    chk("R9", 32'(issuePc), 32'h0000);

    // random mix of branches and commit requests
    for (int i = 0; i < 400; i++) begin
      logic       br  = ($urandom % 4) == 0;
      logic [2:0] tid = 3'($urandom % 8);
      logic [15:0] tg = 16'($urandom);
      logic       wb  = 1'($urandom % 2);
      if ((i % 37) == 0) begin br = 1'b1; tid = 3'(mCnt); end
      cyc(br, tid, tg, wb, "R5");
    end

    summary();
    $finish;
  end
endmodule